// File: doc/BRIEF.md
# Synthesiser Tuning Loop: Reference Divider, Oscillator Divider and Phase Comparator

This block is the digital half of a frequency-synthesiser tuning loop. A reference divider
turns ticks of a slow crystal time base (nominally 75 kHz) into one of seven comparison
rates: 25, 12.5, 6.25, 5, 3.125, 3 or 1 kHz. A programmable divider turns ticks of the local
oscillator into a divided oscillator tick, once every N input ticks. In the high band the
divider models a dual-modulus 16/17 prescaler driven by a swallow counter. In the low band
it counts the oscillator ticks directly.

A three-state phase/frequency comparator compares the two divided tick trains. It drives
the charge-pump pin high when the divided oscillator leads, and low when the reference
leads. It releases the pin when the two arrive together or when neither has arrived.

- A dead-zone setting holds back short correction pulses.
- A sticky unlock flag records any lead window that spans more than one crystal tick.
- Software clears the flag with a read strobe.
- While the loop is held (power-down, halt or loop stop) or in reset, the pin is released.

All inputs are synchronous to `clk`. The crystal and oscillator inputs are one-cycle
enables, not clocks.

The oscillator divider is a state machine:
- `DV_DIRECT`: low-band counting of N ticks.
- `DV_SWALLOW`: prescaler at 17.
- `DV_MAIN`: prescaler at 16.

At every terminal count it moves to `DV_DIRECT` (low band), to `DV_SWALLOW` (high band with a
non-zero swallow field) or to `DV_MAIN` (high band, swallow field zero). It moves from
`DV_SWALLOW` to `DV_MAIN` when the swallow count runs out.

The comparator is a state machine:
- `PF_RELEASED` goes to `PF_LEAD_OSC` on an oscillator tick alone.
- `PF_RELEASED` goes to `PF_LEAD_REF` on a reference tick alone.
- `PF_LEAD_OSC` returns to `PF_RELEASED` on a reference tick.
- `PF_LEAD_REF` returns to `PF_RELEASED` on an oscillator tick.
- Every state goes to `PF_RELEASED` on hold.

Top module: `tune_pll_core`

## Requirements
- R1: `ref_tick_o` pulses for one cycle, one cycle after every Kth `xtal_tick`, with K set by `ref_sel`: code 0→75, 1→25, 2→24, 3→15, 4→12, 5→6, 6→3, 7→3.
- R2: A change of `ref_sel` takes effect only after the current reference period ends; the period in progress keeps its old length.
- R3: With `band_fm`=0 the divider counts `lo_tick` directly. `div_tick_o` pulses one cycle after every Nth `lo_tick`, with N=`div_n` (N≥2).
- R4: With `band_fm`=1 the divider uses a 16/17 prescaler with a swallow count A=`div_n`[3:0] and a main count M=`div_n`[NW-1:4]. The period is 17·A+16·(M−A)=`div_n` oscillator ticks, valid for M≥A and M≥1.
- R5: `div_n` and `band_fm` are sampled only at a terminal count; the period in progress keeps the old value.
- R6: When only the oscillator side has arrived, `eo_drive`=1 with `eo_level`=1 (high). When only the reference side has arrived, `eo_drive`=1 with `eo_level`=0 (low). Coincident ticks, or none, leave `eo_drive`=0 (released).
- R7: In a lead state the pin is driven only from the cycle in which the state has lasted `dz_sel` cycles. A lead of `dz_sel` cycles or fewer never drives the pin.
- R8: `unlock_flag` is set once a lead window has seen two or more `xtal_tick`s, and it stays set.
- R9: A one-cycle `unlock_clr` pulse clears `unlock_flag` when no new unlock event occurs in that cycle.
- R10: While `pll_hold`=1 the pin is released and the dividers and comparator are reinitialised; `unlock_flag` keeps its value.
- R11: During reset `eo_drive`, `eo_level`, `unlock_flag`, `ref_tick_o` and `div_tick_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pll_hold | input | 1 | Power-down, halt or loop stop: releases the pin |
| xtal_tick | input | 1 | One-cycle enable per crystal period |
| lo_tick | input | 1 | One-cycle enable per local-oscillator edge |
| band_fm | input | 1 | 1: high band with 16/17 prescaler; 0: direct count |
| ref_sel | input | 3 | Reference rate code |
| div_n | input | NW | Programmable divide value N |
| dz_sel | input | 2 | Dead-zone width in cycles |
| unlock_clr | input | 1 | Read strobe that clears the unlock flag |
| eo_drive | output | 1 | 1: charge-pump pin driven; 0: released |
| eo_level | output | 1 | Driven level: 1 high, 0 low |
| unlock_flag | output | 1 | Sticky unlock indication |
| ref_tick_o | output | 1 | Divided reference tick |
| div_tick_o | output | 1 | Divided oscillator tick |

## Verification
All eight reference codes are swept, and the measured tick period is compared with its ratio. A rate change made mid-period shows whether reloading waits for the terminal count.

The divider is driven with low-band values, including the minimum of 2, and with high-band values whose swallow field is 0, mid-range and at the maximum allowed by the main field. These values separate the 16-only, mixed and 17-only prescaler sequences.

The comparator is exercised with four tick trains:
- Phase-aligned equal rates must never drive the pin.
- A faster oscillator must drive only high and raise the unlock flag.
- A slower oscillator must drive only low.
- A one-cycle reference lead must drive low with dead zone 0 and nothing with dead zone 1.

// File: rtl/tune_pll_pkg.sv
package tune_pll_pkg;

    localparam int REF_CW = 7;

    typedef enum logic [1:0] {
        PF_RELEASED = 2'd0,
        PF_LEAD_OSC = 2'd1,
        PF_LEAD_REF = 2'd2
    } pfd_state_t;

    typedef enum logic [1:0] {
        DV_DIRECT  = 2'd0,
        DV_SWALLOW = 2'd1,
        DV_MAIN    = 2'd2
    } div_state_t;

    // crystal ticks per reference period for each rate code
    function automatic logic [REF_CW-1:0] ref_ratio(input logic [2:0] code);
        logic [REF_CW-1:0] r;
        unique case (code)
            3'd0: r = 7'd75;
            3'd1: r = 7'd25;
            3'd2: r = 7'd24;
            3'd3: r = 7'd15;
            3'd4: r = 7'd12;
            3'd5: r = 7'd6;
            default: r = 7'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tpl_ref_div.sv
module tpl_ref_div
    import tune_pll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       xtal_tick,
    input  logic [2:0] sel,
    output logic       ref_tick
);
    logic [REF_CW-1:0] cnt, cnt_n;
    logic              tick_n;

    always_comb begin
        cnt_n  = cnt;
        tick_n = 1'b0;
        if (xtal_tick) begin
            if (cnt == '0) begin
                tick_n = 1'b1;
                cnt_n  = ref_ratio(sel) - 7'd1;
            end else begin
                cnt_n = cnt - 7'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            ref_tick <= 1'b0;
        end else if (hold) begin
            cnt      <= '0;
            ref_tick <= 1'b0;
        end else begin
            cnt      <= cnt_n;
            ref_tick <= tick_n;
        end
    end
endmodule

// File: rtl/tpl_lo_div.sv
module tpl_lo_div
    import tune_pll_pkg::*;
#(
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          lo_tick,
    input  logic          band_fm,
    input  logic [NW-1:0] div_n,
    output logic          div_tick
);
    localparam int AW = 4;
    localparam int PW = 5;
    localparam logic [PW-1:0] PRE_END17 = 5'd16;
    localparam logic [PW-1:0] PRE_END16 = 5'd15;

    div_state_t    st, st_n;
    logic [PW-1:0] pc, pc_n;
    logic [NW-1:0] m_left, m_n;
    logic [AW-1:0] a_left, a_n;
    logic          term;

    always_comb begin
        st_n = st;
        pc_n = pc;
        m_n  = m_left;
        a_n  = a_left;
        term = 1'b0;
        if (lo_tick) begin
            unique case (st)
                DV_DIRECT: begin
                    if (m_left <= NW'(1)) term = 1'b1;
                    else                  m_n  = m_left - NW'(1);
                end
                DV_SWALLOW, DV_MAIN: begin
                    if (pc == ((st == DV_SWALLOW) ? PRE_END17 : PRE_END16)) begin
                        pc_n = '0;
                        if (m_left <= NW'(1)) begin
                            term = 1'b1;
                        end else begin
                            m_n = m_left - NW'(1);
                            if (st == DV_SWALLOW) begin
                                a_n = a_left - 4'd1;
                                if (a_left == 4'd1) st_n = DV_MAIN;
                            end
                        end
                    end else begin
                        pc_n = pc + 5'd1;
                    end
                end
                default: st_n = DV_DIRECT;
            endcase
            if (term) begin
                pc_n = '0;
                if (band_fm) begin
                    m_n  = {{AW{1'b0}}, div_n[NW-1:AW]};
                    a_n  = div_n[AW-1:0];
                    st_n = (div_n[AW-1:0] != '0) ? DV_SWALLOW : DV_MAIN;
                end else begin
                    m_n  = div_n;
                    a_n  = '0;
                    st_n = DV_DIRECT;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= DV_DIRECT;
            pc       <= '0;
            m_left   <= NW'(1);
            a_left   <= '0;
            div_tick <= 1'b0;
        end else if (hold) begin
            st       <= DV_DIRECT;
            pc       <= '0;
            m_left   <= NW'(1);
            a_left   <= '0;
            div_tick <= 1'b0;
        end else begin
            st       <= st_n;
            pc       <= pc_n;
            m_left   <= m_n;
            a_left   <= a_n;
            div_tick <= term;
        end
    end
endmodule

// File: rtl/tpl_pfd.sv
module tpl_pfd
    import tune_pll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       ref_tick,
    input  logic       div_tick,
    input  logic       xtal_tick,
    input  logic [1:0] dz_sel,
    input  logic       unlock_clr,
    output logic       eo_drive,
    output logic       eo_level,
    output logic       unlock_flag
);
    pfd_state_t st, st_n;
    logic [1:0] wid, wid_n;
    logic [1:0] tk, tk_n;
    logic [2:0] tk_inc;
    logic       lead;
    logic       unlock_set;

    always_comb begin
        st_n = st;
        unique case (st)
            PF_RELEASED: begin
                if (div_tick && !ref_tick)      st_n = PF_LEAD_OSC;
                else if (ref_tick && !div_tick) st_n = PF_LEAD_REF;
            end
            PF_LEAD_OSC: if (ref_tick) st_n = PF_RELEASED;
            PF_LEAD_REF: if (div_tick) st_n = PF_RELEASED;
            default:     st_n = PF_RELEASED;
        endcase
    end

    assign lead   = (st != PF_RELEASED);
    assign tk_inc = {1'b0, tk} + {2'b00, xtal_tick};

    always_comb begin
        wid_n      = 2'd0;
        tk_n       = 2'd0;
        unlock_set = lead && (tk_inc >= 3'd2);
        if (lead && (st_n == st)) begin
            wid_n = (wid == 2'd3) ? wid : wid + 2'd1;
            tk_n  = (tk_inc >= 3'd2) ? 2'd2 : tk_inc[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PF_RELEASED;
            wid <= '0;
            tk  <= '0;
        end else if (hold) begin
            st  <= PF_RELEASED;
            wid <= '0;
            tk  <= '0;
        end else begin
            st  <= st_n;
            wid <= wid_n;
            tk  <= tk_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   unlock_flag <= 1'b0;
        else if (unlock_set && !hold) unlock_flag <= 1'b1;
        else if (unlock_clr)          unlock_flag <= 1'b0;
    end

    always_comb begin
        eo_drive = lead && (wid >= dz_sel) && !hold;
        eo_level = eo_drive && (st == PF_LEAD_OSC);
    end
endmodule

// File: rtl/tune_pll_core.sv
module tune_pll_core #(
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_hold,
    input  logic          xtal_tick,
    input  logic          lo_tick,
    input  logic          band_fm,
    input  logic [2:0]    ref_sel,
    input  logic [NW-1:0] div_n,
    input  logic [1:0]    dz_sel,
    input  logic          unlock_clr,
    output logic          eo_drive,
    output logic          eo_level,
    output logic          unlock_flag,
    output logic          ref_tick_o,
    output logic          div_tick_o
);
    tpl_ref_div u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (pll_hold),
        .xtal_tick(xtal_tick),
        .sel      (ref_sel),
        .ref_tick (ref_tick_o)
    );

    tpl_lo_div #(.NW(NW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (pll_hold),
        .lo_tick (lo_tick),
        .band_fm (band_fm),
        .div_n   (div_n),
        .div_tick(div_tick_o)
    );

    tpl_pfd u_pfd (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (pll_hold),
        .ref_tick   (ref_tick_o),
        .div_tick   (div_tick_o),
        .xtal_tick  (xtal_tick),
        .dz_sel     (dz_sel),
        .unlock_clr (unlock_clr),
        .eo_drive   (eo_drive),
        .eo_level   (eo_level),
        .unlock_flag(unlock_flag)
    );
endmodule

// File: rtl/tpl_chk.sv
module tpl_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_hold,
    input logic xtal_tick,
    input logic lo_tick,
    input logic unlock_clr,
    input logic eo_drive,
    input logic eo_level,
    input logic unlock_flag,
    input logic ref_tick_o,
    input logic div_tick_o
);
    // R1
    ref_follows_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick_o |-> $past(xtal_tick));

    // R1
    ref_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick_o |=> !ref_tick_o);

    // R3
    div_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick_o |-> $past(lo_tick));

    // R6
    coincide_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick_o && div_tick_o) |=> !eo_drive);

    // R6
    level_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eo_level |-> eo_drive);

    // R8
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_flag && !unlock_clr) |=> unlock_flag);

    // R9
    unlock_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock_flag) |-> $past(unlock_clr));

    // R10
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_hold |=> (!eo_drive && !ref_tick_o && !div_tick_o));
endmodule

bind tune_pll_core tpl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_hold   (pll_hold),
    .xtal_tick  (xtal_tick),
    .lo_tick    (lo_tick),
    .unlock_clr (unlock_clr),
    .eo_drive   (eo_drive),
    .eo_level   (eo_level),
    .unlock_flag(unlock_flag),
    .ref_tick_o (ref_tick_o),
    .div_tick_o (div_tick_o)
);

// File: tb/sim_tune_pll_core.sv
module sim_tune_pll_core;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_hold = 1'b0;
    logic          xtal_tick = 1'b0;
    logic          lo_tick = 1'b0;
    logic          band_fm = 1'b0;
    logic [2:0]    ref_sel = 3'd6;
    logic [NW-1:0] div_n = 12'd6;
    logic [1:0]    dz_sel = 2'd0;
    logic          unlock_clr = 1'b0;
    logic          eo_drive, eo_level, unlock_flag, ref_tick_o, div_tick_o;

    tune_pll_core #(.NW(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .pll_hold(pll_hold), .xtal_tick(xtal_tick),
        .lo_tick(lo_tick), .band_fm(band_fm), .ref_sel(ref_sel), .div_n(div_n),
        .dz_sel(dz_sel), .unlock_clr(unlock_clr), .eo_drive(eo_drive),
        .eo_level(eo_level), .unlock_flag(unlock_flag), .ref_tick_o(ref_tick_o),
        .div_tick_o(div_tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, failed = 0;
    int t = 0;
    bit rst_pend = 1'b0;
    int lo_ph = 0;
    int ref_cnt = 0, ref_per = 0, ref_n = 0;
    int div_cnt = 0, div_per = 0, div_n_cnt = 0;
    int hi_c = 0, lo_c = 0;
    bit done = 1'b0;

    // stimulus generator: crystal tick every 4 cycles, oscillator tick every 2
    initial forever begin
        @(posedge clk);
        #1;
        t = t + 1;
        if (rst_pend && (t % 4 == 0)) begin
            rst_n = 1'b1;
            rst_pend = 1'b0;
        end
        xtal_tick = (t % 4 == 0);
        lo_tick   = ((t + lo_ph) % 2 == 0);
    end

    // period and drive monitor, sampled mid-cycle
    initial forever begin
        @(negedge clk);
        if (ref_tick_o) begin ref_per = ref_cnt; ref_cnt = 0; ref_n++; end
        if (xtal_tick) ref_cnt++;
        if (div_tick_o) begin div_per = div_cnt; div_cnt = 0; div_n_cnt++; end
        if (lo_tick) div_cnt++;
        if (eo_drive) begin
            if (eo_level) hi_c++; else lo_c++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    task automatic wait_ref(input int k);
        int target;
        target = ref_n + k;
        while (ref_n < target) @(posedge clk);
        #1;
    endtask

    task automatic wait_div(input int k);
        int target;
        target = div_n_cnt + k;
        while (div_n_cnt < target) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        // R11 reset state
        chk(!eo_drive && !eo_level && !unlock_flag && !ref_tick_o && !div_tick_o,
            "R11 outputs in reset",
            {eo_drive, eo_level, unlock_flag, ref_tick_o, div_tick_o}, 0);
        rst_pend = 1'b1;
        wait (rst_n == 1'b1);
    endtask

    task automatic window(input int settle, input int len);
        repeat (settle) @(posedge clk);
        #1; hi_c = 0; lo_c = 0;
        repeat (len) @(posedge clk);
        #2;
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 75;
            1: return 25;
            2: return 24;
            3: return 15;
            4: return 12;
            5: return 6;
            default: return 3;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        total++; failed++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int am_vals[4];
        int fm_vals[4];
        am_vals = '{2, 3, 7, 100};
        fm_vals = '{16, 33, 84, 255};
        lo_ph = 0;
        do_reset();

        // R1 sweep of all rate codes
        for (int c = 0; c < 8; c++) begin
            ref_sel = 3'(c);
            wait_ref(3);
            chk(ref_per == ratio_of(c), $sformatf("R1 ratio code %0d", c), ref_per, ratio_of(c));
        end

        // R2 mid-period rate change
        ref_sel = 3'd0;
        wait_ref(3);
        repeat (40) @(posedge clk);
        #1; ref_sel = 3'd6;
        wait_ref(1);
        chk(ref_per == 75, "R2 old period kept", ref_per, 75);
        wait_ref(1);
        chk(ref_per == 3, "R2 new period used", ref_per, 3);

        // R3 direct count
        band_fm = 1'b0;
        foreach (am_vals[i]) begin
            div_n = 12'(am_vals[i]);
            wait_div(3);
            chk(div_per == am_vals[i], "R3 direct period", div_per, am_vals[i]);
        end

        // R4 prescaled count, swallow 0, mid and max
        band_fm = 1'b1;
        foreach (fm_vals[i]) begin
            div_n = 12'(fm_vals[i]);
            wait_div(3);
            chk(div_per == fm_vals[i], "R4 prescaled period", div_per, fm_vals[i]);
        end

        // R5 divide value change waits for terminal count
        band_fm = 1'b0;
        div_n = 12'd40;
        wait_div(3);
        repeat (20) @(posedge clk);
        #1; div_n = 12'd9;
        wait_div(1);
        chk(div_per == 40, "R5 old divide kept", div_per, 40);
        wait_div(1);
        chk(div_per == 9, "R5 new divide used", div_per, 9);

        // R6 locked and phase aligned
        band_fm = 1'b0; ref_sel = 3'd6; div_n = 12'd6; dz_sel = 2'd0; lo_ph = 0;
        do_reset();
        window(50, 400);
        chk(hi_c == 0 && lo_c == 0, "R6 aligned never drives", hi_c + lo_c, 0);
        chk(unlock_flag == 1'b0, "R8 aligned no unlock", unlock_flag, 0);

        // R6 oscillator faster
        div_n = 12'd5;
        do_reset();
        window(50, 400);
        chk(lo_c == 0, "R6 fast no low drive", lo_c, 0);
        chk(hi_c > 0, "R6 fast drives high", hi_c, 1);
        chk(unlock_flag == 1'b1, "R8 fast sets unlock", unlock_flag, 1);

        // R10 hold releases and keeps flag
        pll_hold = 1'b1;
        window(0, 30);
        chk(hi_c == 0 && lo_c == 0, "R10 hold releases pin", hi_c + lo_c, 0);
        chk(unlock_flag == 1'b1, "R10 flag kept in hold", unlock_flag, 1);
        // R9 clear strobe
        unlock_clr = 1'b1;
        @(posedge clk); #1;
        unlock_clr = 1'b0;
        #1;
        chk(unlock_flag == 1'b0, "R9 clear strobe", unlock_flag, 0);
        pll_hold = 1'b0;

        // R6 oscillator slower
        div_n = 12'd7;
        do_reset();
        window(50, 400);
        chk(hi_c == 0, "R6 slow no high drive", hi_c, 0);
        chk(lo_c > 0, "R6 slow drives low", lo_c, 1);

        // R7 one-cycle reference lead, dead zone 0 then 1
        div_n = 12'd6; lo_ph = 1; dz_sel = 2'd0;
        do_reset();
        window(50, 240);
        chk(lo_c > 0 && hi_c == 0, "R7 dead zone 0 drives low", lo_c, 20);
        chk(unlock_flag == 1'b0, "R8 short lead no unlock", unlock_flag, 0);
        dz_sel = 2'd1;
        do_reset();
        window(50, 240);
        chk(hi_c == 0 && lo_c == 0, "R7 dead zone 1 suppresses", hi_c + lo_c, 0);

        finish_up();
    end
endmodule